// File: doc/BRIEF.md
# Accumulator ALU with Nibble Flags and Decimal Correction

This block is the byte-wide arithmetic and logic unit of a small accumulator machine. Each cycle it takes an opcode, the accumulator byte and a second operand. It produces the result combinationally, together with a write strobe that tells the register file whether to keep that result. Four condition flags live in a small register inside the block: Zero, Subtract, Half-carry and Carry. These flags feed back into the carry-using operations and into the decimal correction step.

Half-carry always comes from its own low-nibble adder, so it is independent of the full-byte carry. The decimal correction step turns the binary result of the previous BCD add or subtract into a valid packed BCD byte. It decides which fix to apply from the stored Subtract, Half-carry and Carry flags. The flag register loads only in cycles where the operation strobe is high.

Top module: `nibble_alu`

## Requirements
- R1: After reset, `flagsOut` equals parameter `FLAG_RESET`. The flag bit positions are Zero=3, Subtract=2, Half-carry=1, Carry=0. The opcode values are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 complement, 11 set-carry, 12 flip-carry, 13 decimal correct. Values 14 and 15 are reserved.
- R2: Add and add-with-carry produce the result modulo 256 and clear Subtract. Carry is the carry out of bit 7. Half-carry is set when the low-nibble sum exceeds 0xF. Add-with-carry includes the stored Carry in both sums.
- R3: Subtract and subtract-with-borrow produce the result modulo 256 and set Subtract. Carry is set on a borrow out of the byte. Half-carry is set on a borrow out of the low nibble. Subtract-with-borrow also subtracts the stored Carry.
- R4: Compare sets the flags exactly as subtract does, and holds `resultWe` low.
- R5: AND clears Subtract and Carry and sets Half-carry. OR and XOR clear Subtract, Half-carry and Carry.
- R6: Every operation that writes its result, except complement, sets Zero exactly when the result is 0x00.
- R7: Increment and decrement act on `accIn` and leave Carry unchanged. Half-carry comes from the low nibble. Increment clears Subtract and decrement sets it.
- R8: Complement inverts `accIn`, sets Subtract and Half-carry, and leaves Zero and Carry unchanged.
- R9: Set-carry sets Carry and flip-carry inverts it. Both clear Subtract and Half-carry, keep Zero, and hold `resultWe` low.
- R10: Decimal correct with Subtract clear adds 0x06 when Half-carry is set or the low nibble exceeds 9. It adds 0x60 and sets Carry when Carry is set or the byte exceeds 0x99; otherwise Carry is cleared.
- R11: Decimal correct with Subtract set subtracts 0x06 when Half-carry is set and 0x60 when Carry is set. Carry keeps its value. In both directions, Half-carry is cleared, Subtract is kept, and Zero follows the result.
- R12: With `opValid` low, or with a reserved opcode, the flags do not change and `resultWe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Execute strobe; the flags load on this cycle's edge |
| opCode | input | 4 | Operation select |
| accIn | input | 8 | Accumulator byte |
| operand | input | 8 | Second operand |
| result | output | 8 | Combinational result |
| resultWe | output | 1 | Result should be written back |
| flagsOut | output | 4 | Registered flags {Z,N,H,C} |

## Verification
The bench builds the block with `FLAG_RESET` set to Carry only. This lets the very first add-with-carry after reset show that the reset flag value feeds the arithmetic, with no extra setup operation. Flags are then carried from one directed operation to the next. This reaches every decimal correction path: low fix, high fix, both fixes, wrap to zero, and both subtract fixes. It also reaches increment and decrement under both Carry values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int FLAG_W = 4;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
    OP_INC = 4'd8, OP_DEC = 4'd9, OP_CPL = 4'd10, OP_SCF = 4'd11,
    OP_CCF = 4'd12, OP_DAA = 4'd13, OP_RSV0 = 4'd14, OP_RSV1 = 4'd15
  } aluOp_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } aluFlags_t;

  typedef enum logic [2:0] {
    K_NONE, K_ARITH, K_LOGIC, K_CPL, K_CARRY, K_DAA
  } aluKind_e;

  typedef enum logic [1:0] { L_AND, L_OR, L_XOR } logicSel_e;

  typedef struct packed {
    aluKind_e  kind;
    logic      subEn;
    logic      carryInEn;
    logic      stepEn;
    logicSel_e logicSel;
    logic      carryFlip;
    logic      writeRes;
  } aluStrobe_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  aluOp_e     opCode,
  output aluStrobe_t strobe
);
  always_comb begin
    strobe = '{kind: K_NONE, subEn: 1'b0, carryInEn: 1'b0, stepEn: 1'b0,
               logicSel: L_AND, carryFlip: 1'b0, writeRes: 1'b0};
    unique case (opCode)
      OP_ADD: begin strobe.kind = K_ARITH; strobe.writeRes = 1'b1; end
      OP_ADC: begin strobe.kind = K_ARITH; strobe.carryInEn = 1'b1; strobe.writeRes = 1'b1; end
      OP_SUB: begin strobe.kind = K_ARITH; strobe.subEn = 1'b1; strobe.writeRes = 1'b1; end
      OP_SBC: begin
        strobe.kind = K_ARITH; strobe.subEn = 1'b1;
        strobe.carryInEn = 1'b1; strobe.writeRes = 1'b1;
      end
      OP_CMP: begin strobe.kind = K_ARITH; strobe.subEn = 1'b1; end
      OP_AND: begin strobe.kind = K_LOGIC; strobe.logicSel = L_AND; strobe.writeRes = 1'b1; end
      OP_OR:  begin strobe.kind = K_LOGIC; strobe.logicSel = L_OR;  strobe.writeRes = 1'b1; end
      OP_XOR: begin strobe.kind = K_LOGIC; strobe.logicSel = L_XOR; strobe.writeRes = 1'b1; end
      OP_INC: begin strobe.kind = K_ARITH; strobe.stepEn = 1'b1; strobe.writeRes = 1'b1; end
      OP_DEC: begin
        strobe.kind = K_ARITH; strobe.stepEn = 1'b1;
        strobe.subEn = 1'b1; strobe.writeRes = 1'b1;
      end
      OP_CPL: begin strobe.kind = K_CPL; strobe.writeRes = 1'b1; end
      OP_SCF: begin strobe.kind = K_CARRY; end
      OP_CCF: begin strobe.kind = K_CARRY; strobe.carryFlip = 1'b1; end
      OP_DAA: begin strobe.kind = K_DAA; strobe.writeRes = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
(
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  aluFlags_t         flagsCur,
  output logic [DATA_W-1:0] result,
  output aluFlags_t         flagsNxt
);
  localparam logic [DATA_W-1:0] LOW_FIX  = DATA_W'(8'h06);
  localparam logic [DATA_W-1:0] HIGH_FIX = DATA_W'(8'h60);
  localparam logic [DATA_W-1:0] BCD_MAX  = DATA_W'(8'h99);
  localparam logic [NIB_W-1:0]  NIB_MAX  = NIB_W'(9);

  logic [DATA_W-1:0] bOp;
  logic [DATA_W:0]   wideRes;
  logic [NIB_W:0]    lowRes;
  logic              cin;
  logic [DATA_W-1:0] daaAdj;
  logic              daaLow, daaHigh;

  always_comb begin
    bOp = strobe.stepEn ? DATA_W'(1) : operand;
    cin = strobe.carryInEn & flagsCur.c;
    if (strobe.subEn) begin
      wideRes = {1'b0, accIn} - {1'b0, bOp} - (DATA_W+1)'(cin);
      lowRes  = {1'b0, accIn[NIB_W-1:0]} - {1'b0, bOp[NIB_W-1:0]} - (NIB_W+1)'(cin);
    end else begin
      wideRes = {1'b0, accIn} + {1'b0, bOp} + (DATA_W+1)'(cin);
      lowRes  = {1'b0, accIn[NIB_W-1:0]} + {1'b0, bOp[NIB_W-1:0]} + (NIB_W+1)'(cin);
    end
  end

  always_comb begin
    if (flagsCur.n) begin
      daaLow  = flagsCur.h;
      daaHigh = flagsCur.c;
    end else begin
      daaLow  = flagsCur.h | (accIn[NIB_W-1:0] > NIB_MAX);
      daaHigh = flagsCur.c | (accIn > BCD_MAX);
    end
    daaAdj = (daaLow ? LOW_FIX : '0) | (daaHigh ? HIGH_FIX : '0);
  end

  always_comb begin
    result   = accIn;
    flagsNxt = flagsCur;
    unique case (strobe.kind)
      K_ARITH: begin
        result     = wideRes[DATA_W-1:0];
        flagsNxt.z = (wideRes[DATA_W-1:0] == '0);
        flagsNxt.n = strobe.subEn;
        flagsNxt.h = lowRes[NIB_W];
        if (!strobe.stepEn) flagsNxt.c = wideRes[DATA_W];
      end
      K_LOGIC: begin
        unique case (strobe.logicSel)
          L_AND:   result = accIn & operand;
          L_OR:    result = accIn | operand;
          default: result = accIn ^ operand;
        endcase
        flagsNxt.z = (result == '0);
        flagsNxt.n = 1'b0;
        flagsNxt.h = (strobe.logicSel == L_AND);
        flagsNxt.c = 1'b0;
      end
      K_CPL: begin
        result     = ~accIn;
        flagsNxt.n = 1'b1;
        flagsNxt.h = 1'b1;
      end
      K_CARRY: begin
        flagsNxt.n = 1'b0;
        flagsNxt.h = 1'b0;
        flagsNxt.c = strobe.carryFlip ? ~flagsCur.c : 1'b1;
      end
      K_DAA: begin
        result     = flagsCur.n ? accIn - daaAdj : accIn + daaAdj;
        flagsNxt.z = (result == '0);
        flagsNxt.h = 1'b0;
        flagsNxt.c = flagsCur.n ? flagsCur.c : daaHigh;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flagfile.sv
module alu_flagfile
  import alu_pkg::*;
#(
  parameter logic [FLAG_W-1:0] RESET_VAL = '0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadEn,
  input  aluFlags_t flagsNxt,
  output aluFlags_t flagsCur
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flagsCur <= aluFlags_t'(RESET_VAL);
    else if (loadEn) flagsCur <= flagsNxt;
  end
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import alu_pkg::*;
#(
  parameter logic [3:0] FLAG_RESET = 4'b0000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic [7:0] accIn,
  input  logic [7:0] operand,
  output logic [7:0] result,
  output logic       resultWe,
  output logic [3:0] flagsOut
);
  aluStrobe_t strobe;
  aluFlags_t  flagsCur, flagsNxt;

  alu_ctrl u_ctrl (.opCode(aluOp_e'(opCode)), .strobe(strobe));

  alu_datapath u_dp (
    .strobe(strobe), .accIn(accIn), .operand(operand),
    .flagsCur(flagsCur), .result(result), .flagsNxt(flagsNxt)
  );

  alu_flagfile #(.RESET_VAL(FLAG_RESET)) u_flags (
    .clk(clk), .rstN(rstN), .loadEn(opValid),
    .flagsNxt(flagsNxt), .flagsCur(flagsCur)
  );

  assign resultWe = opValid & strobe.writeRes;
  assign flagsOut = flagsCur;
endmodule

// File: rtl/nibble_alu_checker.sv
module nibble_alu_checker (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [3:0] opCode,
  input logic [7:0] accIn,
  input logic [7:0] operand,
  input logic [7:0] result,
  input logic       resultWe,
  input logic [3:0] flagsOut
);
  // R4 / R9: compare and carry operations never write back
  assert_no_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 4'd4 || opCode == 4'd11 || opCode == 4'd12)) |-> !resultWe);

  // R12: idle cycles keep the flags
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flagsOut));

  // R7: increment and decrement keep Carry
  assert_step_carry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 4'd8 || opCode == 4'd9)) |=> flagsOut[0] == $past(flagsOut[0]));

  // R5: logic operations clear Subtract and Carry
  assert_logic_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= 4'd5 && opCode <= 4'd7) |=> (!flagsOut[2] && !flagsOut[0]));

  // R6: Zero follows the written result
  assert_zero_track_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resultWe && opCode != 4'd10) |=> flagsOut[3] == ($past(result) == 8'h00));

  // R11: decimal correction clears Half-carry and keeps Subtract
  assert_daa_flags_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd13) |=> (!flagsOut[1] && flagsOut[2] == $past(flagsOut[2])));
endmodule

bind nibble_alu nibble_alu_checker u_chk (.*);

// File: tb/nibble_alu_bench.sv
module nibble_alu_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] accIn = 8'h00;
  logic [7:0] operand = 8'h00;
  logic [7:0] result;
  logic       resultWe;
  logic [3:0] flagsOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] resSeen;
  logic       weSeen;

  always #2 clk = ~clk;

  nibble_alu #(.FLAG_RESET(4'b0001)) u_nibble_alu (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // drive one operation; result sampled mid-cycle, flags after the edge
  task automatic doOp(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    opValid = 1'b1; opCode = op; accIn = a; operand = b;
    #1;
    resSeen = result; weSeen = resultWe;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic opCheck(input string req, input logic [3:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] expRes, input logic expWe,
                         input logic [3:0] expFlags);
    doOp(op, a, b);
    if (expWe) chk({req, " result"}, resSeen, expRes);
    chk({req, " write"}, {7'd0, weSeen}, {7'd0, expWe});
    chk({req, " flags"}, {4'd0, flagsOut}, {4'd0, expFlags});
  endtask

  task automatic testReset();
    chk("R1 reset flags", {4'd0, flagsOut}, 8'h01);
  endtask

  task automatic testAdd();
    opCheck("R2 adc reset carry", 4'd1, 8'h0F, 8'h00, 8'h10, 1'b1, 4'b0010);
    opCheck("R2 add wrap R6", 4'd0, 8'hFF, 8'h01, 8'h00, 1'b1, 4'b1011);
    opCheck("R2 add plain", 4'd0, 8'h12, 8'h34, 8'h46, 1'b1, 4'b0000);
    opCheck("R9 scf", 4'd11, 8'h00, 8'h00, 8'h00, 1'b0, 4'b0001);
    opCheck("R2 adc carry in", 4'd1, 8'h7F, 8'h80, 8'h00, 1'b1, 4'b1011);
  endtask

  task automatic testSub();
    opCheck("R3 sub nibble borrow", 4'd2, 8'h10, 8'h01, 8'h0F, 1'b1, 4'b0110);
    opCheck("R3 sub byte borrow", 4'd2, 8'h01, 8'h02, 8'hFF, 1'b1, 4'b0111);
    opCheck("R3 sbc borrow in", 4'd3, 8'h20, 8'h1F, 8'h00, 1'b1, 4'b1110);
    opCheck("R4 cmp equal", 4'd4, 8'h42, 8'h42, 8'h00, 1'b0, 4'b1100);
  endtask

  task automatic testLogic();
    opCheck("R5 and", 4'd5, 8'hF0, 8'h3C, 8'h30, 1'b1, 4'b0010);
    opCheck("R5 and zero R6", 4'd5, 8'h0F, 8'hF0, 8'h00, 1'b1, 4'b1010);
    opCheck("R5 or zero", 4'd6, 8'h00, 8'h00, 8'h00, 1'b1, 4'b1000);
    opCheck("R5 xor", 4'd7, 8'h5A, 8'hFF, 8'hA5, 1'b1, 4'b0000);
  endtask

  task automatic testStep();
    opCheck("R9 scf", 4'd11, 8'h00, 8'h00, 8'h00, 1'b0, 4'b0001);
    opCheck("R7 inc nibble", 4'd8, 8'h0F, 8'h00, 8'h10, 1'b1, 4'b0011);
    opCheck("R7 inc wrap", 4'd8, 8'hFF, 8'h00, 8'h00, 1'b1, 4'b1011);
    opCheck("R7 dec nibble", 4'd9, 8'h10, 8'h00, 8'h0F, 1'b1, 4'b0111);
    opCheck("R7 dec zero", 4'd9, 8'h01, 8'h00, 8'h00, 1'b1, 4'b1101);
    opCheck("R9 ccf", 4'd12, 8'h00, 8'h00, 8'h00, 1'b0, 4'b1000);
    opCheck("R7 dec carry clear", 4'd9, 8'h01, 8'h00, 8'h00, 1'b1, 4'b1100);
    opCheck("R8 cpl", 4'd10, 8'h35, 8'h00, 8'hCA, 1'b1, 4'b1110);
  endtask

  task automatic testDaaAdd();
    opCheck("R10 setup", 4'd0, 8'h15, 8'h27, 8'h3C, 1'b1, 4'b0000);
    opCheck("R10 low digit", 4'd13, 8'h3C, 8'h00, 8'h42, 1'b1, 4'b0000);
    opCheck("R10 setup h", 4'd0, 8'h19, 8'h28, 8'h41, 1'b1, 4'b0010);
    opCheck("R10 half carry", 4'd13, 8'h41, 8'h00, 8'h47, 1'b1, 4'b0000);
    opCheck("R10 setup c", 4'd0, 8'h90, 8'h90, 8'h20, 1'b1, 4'b0001);
    opCheck("R10 carry", 4'd13, 8'h20, 8'h00, 8'h80, 1'b1, 4'b0001);
    opCheck("R10 setup both", 4'd0, 8'h99, 8'h01, 8'h9A, 1'b1, 4'b0000);
    opCheck("R10 both wrap", 4'd13, 8'h9A, 8'h00, 8'h00, 1'b1, 4'b1001);
  endtask

  task automatic testDaaSub();
    opCheck("R11 setup h", 4'd2, 8'h42, 8'h15, 8'h2D, 1'b1, 4'b0110);
    opCheck("R11 low fix", 4'd13, 8'h2D, 8'h00, 8'h27, 1'b1, 4'b0100);
    opCheck("R11 setup c", 4'd2, 8'h15, 8'h42, 8'hD3, 1'b1, 4'b0101);
    opCheck("R11 high fix", 4'd13, 8'hD3, 8'h00, 8'h73, 1'b1, 4'b0101);
    opCheck("R11 setup z", 4'd2, 8'h10, 8'h10, 8'h00, 1'b1, 4'b1100);
    opCheck("R11 no fix", 4'd13, 8'h00, 8'h00, 8'h00, 1'b1, 4'b1100);
  endtask

  task automatic testHold();
    @(negedge clk);
    opValid = 1'b0; opCode = 4'd0; accIn = 8'hFF; operand = 8'h01;
    #1;
    chk("R12 idle write", {7'd0, resultWe}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R12 idle flags", {4'd0, flagsOut}, 8'h0C);
    opCheck("R12 reserved", 4'd14, 8'h00, 8'h00, 8'h00, 1'b0, 4'b1100);
    opCheck("R12 reserved2", 4'd15, 8'hFF, 8'h01, 8'h00, 1'b0, 4'b1100);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAdd();
    testSub();
    testLogic();
    testStep();
    testDaaAdd();
    testDaaSub();
    testHold();
    finishRun();
  end

  initial begin
    #(4 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end
endmodule